// File: doc/BRIEF.md
# Bridge Control and Status Register

This block holds the 32-bit control and status word of a bus bridge controller. Software on the host register bus writes and reads it at one address. The peripheral bus sees the same word through a read port that has no write path. The writable fields set a soft reset for the controller, an initialization-complete flag that decides whether incoming target cycles are retried or accepted, two byte-lane swap enables, a host-bus endianness select and a doorbell test mode. Each of these fields leaves the block as a plain level output.

Two of the fields are not plain storage. Writing 1 to the system-error request field sends one toggle event from the host clock domain to the peripheral clock domain. There it produces a single-cycle low pulse on the active-low system-error output, but only if the error-enable input from another register is set in that cycle. The two lowest bits report two strap pins. These are captured on the first host clock edge after the system reset is released, and they stay fixed until the next system reset. The soft reset does not capture them again.

Each clock domain has its own reset synchronizer. The asynchronous active-low system reset takes effect at once and is released in step with the local clock.

Top module: `bridge_ctl_reg`

## Requirements
- R1: Bits 31:17, 14:9 and 7:6 always read as 0 from both buses, and writing 1 to them has no effect.
- R2: A host write at address REG_OFFSET (0x1C) stores bits 16, 15, 5, 4, 3 and 2, and a host read at that address returns them. A host write at any other address changes nothing, and a host read at any other address returns 0.
- R3: After a system reset, every writable bit reads 0. `ctl_rst` is 1 exactly while bit 16 is 1, which holds the controller in reset and floats its outputs.
- R4: While bit 16 is 0 and `tgt_req` is 1, `tgt_retry` equals NOT bit 15 and `tgt_accept` equals bit 15. While bit 16 is 1 or `tgt_req` is 0, both outputs are 0. The two outputs are never 1 together.
- R5: When `serr_en` is 1, a host write at REG_OFFSET with bit 8 set drives `serr_n` low for exactly one `pclk` cycle, within SYNC_STAGES+3 `pclk` cycles. Writes spaced at least that far apart give one pulse each.
- R6: If `serr_en` is 0 when the request reaches the peripheral domain, `serr_n` stays high and the request is dropped.
- R7: Bit 8 always reads 0. It behaves as a self-clearing request.
- R8: Bit 1 reads the `strap_arb` pin and bit 0 reads the `strap_host` pin, both captured on the first `hclk` edge after the synchronized reset release. Changing the pins later, writing to bits 1:0 or setting the soft reset does not change them. A new system reset captures them again.
- R9: `dbell_test` follows bit 5, `host_be` follows bit 4 (0 selects little-endian, 1 selects big-endian), `swap_tgt` follows bit 3 and `swap_slv` follows bit 2.
- R10: `per_rdata` returns the full register word when `per_addr` equals REG_OFFSET, and returns 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Host register bus clock |
| pclk | input | 1 | Peripheral bus clock |
| sys_rst_n | input | 1 | Asynchronous active-low system reset |
| host_addr | input | ADDR_W | Host register bus address |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data |
| per_addr | input | ADDR_W | Peripheral bus read address |
| per_rdata | output | 32 | Peripheral bus read data |
| strap_arb | input | 1 | Arbiter-enable strap pin |
| strap_host | input | 1 | Host-mode strap pin |
| serr_en | input | 1 | System-error enable from another register (pclk domain) |
| tgt_req | input | 1 | An incoming target cycle is being presented |
| tgt_retry | output | 1 | Answer the target cycle with retry |
| tgt_accept | output | 1 | Accept the target cycle |
| serr_n | output | 1 | Active-low system-error pulse (pclk domain) |
| ctl_rst | output | 1 | Soft reset: hold the controller in reset and float its outputs |
| dbell_test | output | 1 | Doorbell test mode enable |
| host_be | output | 1 | Host-bus big-endian addressing |
| swap_tgt | output | 1 | Byte-lane swap for peripheral-to-host target accesses |
| swap_slv | output | 1 | Byte-lane swap for host slave accesses to the peripheral bus |

## Verification
The bench builds the block with SYNC_STAGES=3 and keeps the defaults ADDR_W=8 and REG_OFFSET=0x1C. The host clock runs at 200 MHz and the peripheral clock runs slower on an unrelated period. With a synchronizer deeper than the minimum, the error pulse arrives several cycles after the write and out of phase with the host clock, so the exactly-one-cycle pulse and the one-pulse-per-write rule are checked across a real domain crossing. Because the reset release also runs through three stages, the strap capture comes a measurable time after the pins are set. That lets the bench change the pins after capture, and again under soft reset, and then show that a second system reset captures new values.

// File: rtl/bctl_pkg.sv
package bctl_pkg;
  localparam int REG_W  = 32;
  localparam int B_SRST = 16;
  localparam int B_INIT = 15;
  localparam int B_SERR = 8;
  localparam int B_DBT  = 5;
  localparam int B_BE   = 4;
  localparam int B_SWT  = 3;
  localparam int B_SWS  = 2;
  localparam int B_ARB  = 1;
  localparam int B_HOST = 0;

  typedef struct packed {
    logic srst;
    logic init;
    logic dbt;
    logic be;
    logic swt;
    logic sws;
  } ctl_t;
endpackage

// File: rtl/bctl_rst_sync.sv
module bctl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign rst_n_o = sh_q[STAGES-1];
endmodule

// File: rtl/bctl_pulse_xfer.sv
module bctl_pulse_xfer #(
  parameter int STAGES = 2
) (
  input  logic src_clk,
  input  logic src_rst_n,
  input  logic src_req,
  input  logic dst_clk,
  input  logic dst_rst_n,
  input  logic dst_en,
  output logic dst_pulse_n
);
  logic              tog_q, tog_d;
  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q, prev_d;
  logic              pls_n_q, pls_n_d;
  logic              evt;

  always_comb begin
    tog_d = tog_q ^ src_req;
  end

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n)   tog_q <= 1'b0;
    else if (src_req) tog_q <= tog_d;
  end

  always_comb begin
    sync_d  = {sync_q[STAGES-2:0], tog_q};
    prev_d  = sync_q[STAGES-1];
    evt     = sync_q[STAGES-1] ^ prev_q;
    pls_n_d = ~(evt & dst_en);
  end

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) begin
      sync_q  <= '0;
      prev_q  <= 1'b0;
      pls_n_q <= 1'b1;
    end else begin
      sync_q  <= sync_d;
      prev_q  <= prev_d;
      pls_n_q <= pls_n_d;
    end
  end

  assign dst_pulse_n = pls_n_q;

  // R5
  pulse_one_cycle_chk: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    !dst_pulse_n |=> dst_pulse_n);

  // R6
  pulse_needs_en_chk: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    $fell(dst_pulse_n) |-> $past(dst_en));
endmodule

// File: rtl/bctl_regs.sv
module bctl_regs
  import bctl_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int REG_OFFSET = 'h1C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              strap_arb,
  input  logic              strap_host,
  output ctl_t              ctl_o,
  output logic [1:0]        strap_o,
  output logic              serr_req
);
  localparam logic [ADDR_W-1:0] OFS = ADDR_W'(REG_OFFSET);

  ctl_t       ctl_q, ctl_d;
  logic [1:0] strap_q, strap_d;
  logic       cap_q, cap_d;
  logic       wr_hit;

  always_comb begin
    wr_hit = wr_en && (wr_addr == OFS);
    ctl_d  = ctl_q;
    if (wr_hit) begin
      ctl_d.srst = wr_data[B_SRST];
      ctl_d.init = wr_data[B_INIT];
      ctl_d.dbt  = wr_data[B_DBT];
      ctl_d.be   = wr_data[B_BE];
      ctl_d.swt  = wr_data[B_SWT];
      ctl_d.sws  = wr_data[B_SWS];
    end
    cap_d    = 1'b1;
    strap_d  = cap_q ? strap_q : {strap_arb, strap_host};
    serr_req = wr_hit && wr_data[B_SERR];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      strap_q <= 2'b00;
      cap_q   <= 1'b0;
    end else begin
      if (wr_hit) ctl_q <= ctl_d;
      if (!cap_q) begin
        strap_q <= strap_d;
        cap_q   <= cap_d;
      end
    end
  end

  assign ctl_o   = ctl_q;
  assign strap_o = strap_q;

  // R8
  strap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_q |=> $stable(strap_q));

  // R2
  miss_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == OFS) |=> $stable(ctl_q));
endmodule

// File: rtl/bridge_ctl_reg.sv
module bridge_ctl_reg
  import bctl_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int REG_OFFSET  = 'h1C,
  parameter int SYNC_STAGES = 2
) (
  input  logic              hclk,
  input  logic              pclk,
  input  logic              sys_rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic [REG_W-1:0]  host_wdata,
  output logic [REG_W-1:0]  host_rdata,
  input  logic [ADDR_W-1:0] per_addr,
  output logic [REG_W-1:0]  per_rdata,
  input  logic              strap_arb,
  input  logic              strap_host,
  input  logic              serr_en,
  input  logic              tgt_req,
  output logic              tgt_retry,
  output logic              tgt_accept,
  output logic              serr_n,
  output logic              ctl_rst,
  output logic              dbell_test,
  output logic              host_be,
  output logic              swap_tgt,
  output logic              swap_slv
);
  localparam logic [ADDR_W-1:0] OFS = ADDR_W'(REG_OFFSET);

  logic             h_rst_n, p_rst_n;
  ctl_t             ctl;
  logic [1:0]       strap;
  logic             serr_req;
  logic [REG_W-1:0] word;

  bctl_rst_sync #(.STAGES(SYNC_STAGES)) u_hrst (
    .clk(hclk), .arst_n(sys_rst_n), .rst_n_o(h_rst_n));

  bctl_rst_sync #(.STAGES(SYNC_STAGES)) u_prst (
    .clk(pclk), .arst_n(sys_rst_n), .rst_n_o(p_rst_n));

  bctl_regs #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_regs (
    .clk(hclk), .rst_n(h_rst_n),
    .wr_addr(host_addr), .wr_en(host_wr), .wr_data(host_wdata),
    .strap_arb(strap_arb), .strap_host(strap_host),
    .ctl_o(ctl), .strap_o(strap), .serr_req(serr_req));

  bctl_pulse_xfer #(.STAGES(SYNC_STAGES)) u_serr (
    .src_clk(hclk), .src_rst_n(h_rst_n), .src_req(serr_req),
    .dst_clk(pclk), .dst_rst_n(p_rst_n), .dst_en(serr_en),
    .dst_pulse_n(serr_n));

  always_comb begin
    word         = '0;
    word[B_SRST] = ctl.srst;
    word[B_INIT] = ctl.init;
    word[B_DBT]  = ctl.dbt;
    word[B_BE]   = ctl.be;
    word[B_SWT]  = ctl.swt;
    word[B_SWS]  = ctl.sws;
    word[B_ARB]  = strap[1];
    word[B_HOST] = strap[0];
  end

  assign host_rdata = (host_addr == OFS) ? word : '0;
  assign per_rdata  = (per_addr == OFS) ? word : '0;

  assign tgt_retry  = tgt_req && !ctl.srst && !ctl.init;
  assign tgt_accept = tgt_req && !ctl.srst && ctl.init;

  assign ctl_rst    = ctl.srst;
  assign dbell_test = ctl.dbt;
  assign host_be    = ctl.be;
  assign swap_tgt   = ctl.swt;
  assign swap_slv   = ctl.sws;

  // R4
  retry_accept_excl_chk: assert property (@(posedge hclk) disable iff (!h_rst_n)
    !(tgt_retry && tgt_accept));

  // R1
  rsvd_zero_chk: assert property (@(posedge hclk) disable iff (!h_rst_n)
    (host_rdata[31:17] == '0) && (host_rdata[14:9] == '0) && (host_rdata[7:6] == '0));

  // R7
  serr_bit_zero_chk: assert property (@(posedge hclk) disable iff (!h_rst_n)
    !host_rdata[B_SERR] && !per_rdata[B_SERR]);

  // R4
  srst_blocks_tgt_chk: assert property (@(posedge hclk) disable iff (!h_rst_n)
    ctl_rst |-> !(tgt_retry || tgt_accept));
endmodule

// File: tb/bridge_ctl_reg_tb_top.sv
`timescale 1ns/1ps
module bridge_ctl_reg_tb_top;
  localparam int AW  = 8;
  localparam int OFS = 'h1C;

  logic          hclk = 1'b0, pclk = 1'b0, sys_rst_n = 1'b0;
  logic [AW-1:0] host_addr = '0, per_addr = '0;
  logic          host_wr = 1'b0;
  logic [31:0]   host_wdata = '0;
  logic [31:0]   host_rdata, per_rdata;
  logic          strap_arb = 1'b1, strap_host = 1'b0;
  logic          serr_en = 1'b0, tgt_req = 1'b0;
  logic          tgt_retry, tgt_accept, serr_n, ctl_rst;
  logic          dbell_test, host_be, swap_tgt, swap_slv;

  int checks = 0, errors = 0;
  int low_cnt = 0;
  bit long_low = 0;
  bit prev_low = 0;

  always #2.5 hclk = ~hclk;
  always #3.5 pclk = ~pclk;

  bridge_ctl_reg #(.ADDR_W(AW), .REG_OFFSET(OFS), .SYNC_STAGES(3)) dut_i (
    .hclk(hclk), .pclk(pclk), .sys_rst_n(sys_rst_n),
    .host_addr(host_addr), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .per_addr(per_addr), .per_rdata(per_rdata),
    .strap_arb(strap_arb), .strap_host(strap_host), .serr_en(serr_en),
    .tgt_req(tgt_req), .tgt_retry(tgt_retry), .tgt_accept(tgt_accept),
    .serr_n(serr_n), .ctl_rst(ctl_rst), .dbell_test(dbell_test),
    .host_be(host_be), .swap_tgt(swap_tgt), .swap_slv(swap_slv));

  always @(negedge pclk) begin
    if (sys_rst_n) begin
      if (!serr_n) low_cnt++;
      if (!serr_n && prev_low) long_low = 1;
      prev_low = !serr_n;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hwrite(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge hclk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge hclk);
    host_wr = 1'b0; host_addr = OFS;
  endtask

  task automatic hread(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge hclk);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic do_reset();
    sys_rst_n = 1'b0;
    #20;
    @(negedge hclk);
    sys_rst_n = 1'b1;
    repeat (10) @(negedge hclk);
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    hread(OFS, d);
    chk("R3 reset word (straps arb=1 host=0)", d, 32'h0000_0002);
    chk("R3 ctl_rst after reset", {31'b0, ctl_rst}, 32'h0);
    chk("R9 modes after reset", {28'b0, dbell_test, host_be, swap_tgt, swap_slv}, 32'h0);
  endtask

  task automatic t_masks();
    logic [31:0] d;
    hwrite(OFS, 32'hFFFF_FEFF);
    hread(OFS, d);
    chk("R1 R2 all-ones write keeps only writable bits", d, 32'h0001_803E);
    hwrite(OFS, 32'h0000_0000);
    hread(OFS, d);
    chk("R2 clear writable bits, straps kept R8", d, 32'h0000_0002);
    hwrite(OFS, 32'hFFFE_7FC3);
    hread(OFS, d);
    chk("R1 reserved and strap bits ignore writes", d, 32'h0000_0002);
  endtask

  task automatic t_decode();
    logic [31:0] d;
    hwrite(OFS, 32'h0000_0014);
    hwrite(AW'(OFS + 4), 32'h0001_802C);
    hread(OFS, d);
    chk("R2 write at other address ignored", d, 32'h0000_0016);
    hread(AW'(OFS - 4), d);
    chk("R2 read at other address returns 0", d, 32'h0);
  endtask

  task automatic t_modes();
    hwrite(OFS, 32'h0000_0024);
    #1;
    chk("R9 dbt=1 be=0 swt=0 sws=1", {28'b0, dbell_test, host_be, swap_tgt, swap_slv}, 32'h9);
    hwrite(OFS, 32'h0000_0018);
    #1;
    chk("R9 dbt=0 be=1 swt=1 sws=0", {28'b0, dbell_test, host_be, swap_tgt, swap_slv}, 32'h6);
  endtask

  task automatic t_target();
    hwrite(OFS, 32'h0);
    tgt_req = 1'b1; #1;
    chk("R4 init=0 gives retry", {30'b0, tgt_retry, tgt_accept}, 32'h2);
    hwrite(OFS, 32'h0000_8000); #1;
    chk("R4 init=1 gives accept", {30'b0, tgt_retry, tgt_accept}, 32'h1);
    hwrite(OFS, 32'h0001_8000); #1;
    chk("R4 soft reset blocks target", {30'b0, tgt_retry, tgt_accept}, 32'h0);
    chk("R3 ctl_rst follows bit 16", {31'b0, ctl_rst}, 32'h1);
    tgt_req = 1'b0; #1;
    chk("R4 no request no response", {30'b0, tgt_retry, tgt_accept}, 32'h0);
    hwrite(OFS, 32'h0);
  endtask

  task automatic t_serr();
    logic [31:0] d;
    int base;
    serr_en = 1'b1;
    base = low_cnt;
    hwrite(OFS, 32'h0000_0100);
    repeat (12) @(negedge pclk);
    chk("R5 single write gives one pulse", low_cnt - base, 1);
    hread(OFS, d);
    chk("R7 bit 8 reads 0", d & 32'h100, 32'h0);
    base = low_cnt;
    hwrite(OFS, 32'h0000_0100);
    repeat (12) @(negedge pclk);
    hwrite(OFS, 32'h0000_0100);
    repeat (12) @(negedge pclk);
    chk("R5 two spaced writes give two pulses", low_cnt - base, 2);
    base = low_cnt;
    hwrite(OFS, 32'h0000_0000);
    repeat (12) @(negedge pclk);
    chk("R5 write with bit 8 clear gives no pulse", low_cnt - base, 0);
    serr_en = 1'b0;
    base = low_cnt;
    hwrite(OFS, 32'h0000_0100);
    repeat (12) @(negedge pclk);
    chk("R6 enable low drops request", low_cnt - base, 0);
    chk("R5 no pulse longer than one cycle", {31'b0, long_low}, 32'h0);
  endtask

  task automatic t_straps();
    logic [31:0] d;
    strap_arb = 1'b0; strap_host = 1'b1;
    repeat (3) @(negedge hclk);
    hread(OFS, d);
    chk("R8 pins changed after capture ignored", d & 32'h3, 32'h2);
    hwrite(OFS, 32'h0001_0000);
    repeat (3) @(negedge hclk);
    hread(OFS, d);
    chk("R8 soft reset does not recapture", d & 32'h3, 32'h2);
    do_reset();
    hread(OFS, d);
    chk("R8 new system reset captures arb=0 host=1", d, 32'h0000_0001);
  endtask

  task automatic t_periph();
    hwrite(OFS, 32'h0000_8008);
    per_addr = OFS; #1;
    chk("R10 peripheral read at offset", per_rdata, 32'h0000_8009);
    per_addr = AW'(OFS + 8); #1;
    chk("R10 peripheral read elsewhere", per_rdata, 32'h0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    host_addr = OFS;
    do_reset();
    t_reset_state();
    t_masks();
    t_decode();
    t_modes();
    t_target();
    t_serr();
    t_straps();
    t_periph();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule